// File: doc/BRIEF.md
# Receive Byte Queue with Break Insertion

This block holds the bytes a UART receiver has deserialized until the bus reads them. Bytes arrive on a valid/ready stream from the deserializer and leave on a second valid/ready stream whose ready strobe is the bus read of the receive data register. The queue is four bytes deep and strictly first-in, first-out. A line-break event from the receiver front end also enters the queue, as a zero byte, and raises a sticky break flag that the command decoder clears with a strobe.

Back-pressure rules: on the input side a byte transfers on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while the receiver is enabled, the queue is not full, and neither a flush nor a break event is present in that cycle, so a byte that the deserializer offers while `in_ready` is low stays with the producer. On the output side `out_valid` is the data-ready flag and `out_data` shows the oldest byte. A read strobe (`out_ready`) removes that byte on the clock edge. A strobe while the queue is empty is harmless: `out_data` reads zero and no state moves. A break event does not wait for space. When the queue is full it replaces the newest byte instead of being dropped.

The flush input comes from the receiver-reset command. It empties the queue in one clock and takes priority over every transfer in the same cycle.

Top module: `rx_byte_queue`

## Requirements
- R1: After reset the queue is empty: `out_valid`=0, `full`=0, `brk_flag`=0 and `out_data`=0x00, with `in_ready` following `rx_en`.
- R2: `in_ready` is 1 only when `rx_en`=1, `full`=0, `flush`=0 and `brk_evt`=0. A byte offered while `in_ready`=0 is not stored.
- R3: Bytes accepted on the input stream come out on `out_data` in the order they arrived. The queue never holds more than 4 bytes.
- R4: `full` is 1 exactly when 4 bytes are held, and `out_valid` is 1 exactly when at least one byte is held. A read while full leaves 3 bytes held, so it clears `full`.
- R5: A break event (`brk_evt`=1, no flush) appends the byte 0x00. If the queue is full and no read happens in that cycle, the 0x00 overwrites the most recently written byte and the queue stays full.
- R6: `brk_flag` sets on the clock after any `brk_evt`. It stays set until a `brk_clr` strobe. When `brk_evt` and `brk_clr` occur in the same cycle, the flag stays set.
- R7: While empty, `out_data` is 0x00, and a read strobe changes no state.
- R8: An input transfer and a read in the same cycle are both performed. The number of bytes held is unchanged and order is kept.
- R9: `flush` empties the queue at the next clock. Any input transfer, break byte or read in that cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enabled |
| in_valid | input | 1 | Deserializer offers a byte |
| in_data | input | 8 | Offered byte |
| in_ready | output | 1 | Queue accepts a byte this cycle |
| brk_evt | input | 1 | Line-break event strobe |
| brk_clr | input | 1 | Clear strobe for the break flag |
| flush | input | 1 | Receiver-reset flush strobe |
| out_valid | output | 1 | Data-ready flag, at least one byte held |
| out_data | output | 8 | Oldest byte, or 0x00 when empty |
| out_ready | input | 1 | Bus read strobe of the receive data register |
| full | output | 1 | Four bytes held |
| brk_flag | output | 1 | Sticky break interrupt flag |

## Verification
On every cycle, the assertions check the following: the occupancy bound, that occupancy holds while the receiver is disabled and idle, that a simultaneous transfer and read keep occupancy, that flush empties the queue, that a break on a full queue keeps it full, the set and hold behaviour of the break flag, and the zero data value while empty. Only the directed scenarios can show byte ordering across wrap-around, which byte a break overwrites, that a read on an empty queue does not disturb later data, and that an offered byte is discarded during flush and while the receiver is disabled.

// File: rtl/rbq_pkg.sv
package rbq_pkg;
  // Kind of write the control unit asks the storage array to perform.
  typedef enum logic [1:0] {
    WR_NONE    = 2'd0,
    WR_APPEND  = 2'd1,
    WR_REPLACE = 2'd2
  } wr_kind_e;
endpackage

// File: rtl/rbq_store.sv
module rbq_store #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[g] <= '0;
      end else if (wr_en && (wr_idx == PTR_W'(g))) begin
        slot_q[g] <= wr_data;
      end
    end
  end

  assign rd_data = slot_q[rd_idx];
endmodule

// File: rtl/rbq_ctrl.sv
module rbq_ctrl
  import rbq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic             in_valid,
  input  logic             brk_evt,
  input  logic             flush,
  input  logic             out_ready,
  output logic             in_ready,
  output logic             out_valid,
  output logic             full,
  output logic             wr_en,
  output logic             wr_is_brk,
  output logic [PTR_W-1:0] wr_idx,
  output logic [PTR_W-1:0] rd_idx
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PTR_W-1:0] rd_q, rd_d, tail;
  logic             empty, push_fire, pop_fire, brk_fire;
  wr_kind_e         kind;

  assign empty     = (cnt_q == '0);
  assign full      = (cnt_q == CNT_W'(DEPTH));
  assign out_valid = !empty;

  // Flush and break events take the input slot away from the stream.
  assign in_ready  = rx_en && !full && !flush && !brk_evt;
  assign push_fire = in_valid && in_ready;
  assign pop_fire  = out_ready && !empty && !flush;
  assign brk_fire  = brk_evt && !flush;

  always_comb begin
    kind = WR_NONE;
    if (brk_fire && full && !pop_fire) begin
      kind = WR_REPLACE;
    end else if (brk_fire || push_fire) begin
      kind = WR_APPEND;
    end
  end

  assign tail      = rd_q + PTR_W'(cnt_q);
  assign wr_en     = (kind != WR_NONE);
  assign wr_is_brk = brk_fire;
  assign wr_idx    = (kind == WR_REPLACE) ? (tail - PTR_W'(1)) : tail;
  assign rd_idx    = rd_q;

  always_comb begin
    cnt_d = cnt_q;
    rd_d  = rd_q;
    if (flush) begin
      cnt_d = '0;
      rd_d  = '0;
    end else begin
      case ({kind == WR_APPEND, pop_fire})
        2'b10:   cnt_d = cnt_q + CNT_W'(1);
        2'b01:   cnt_d = cnt_q - CNT_W'(1);
        default: cnt_d = cnt_q;
      endcase
      if (pop_fire) rd_d = rd_q + PTR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rd_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      rd_q  <= rd_d;
    end
  end

  // R3: occupancy never exceeds the depth
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  // R2: disabled receiver with no other activity leaves occupancy alone
  p_disabled_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !brk_evt && !out_ready && !flush) |=> (cnt_q == $past(cnt_q)));

  // R8: transfer plus read keeps occupancy
  p_pop_push_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && out_ready && out_valid) |=> (cnt_q == $past(cnt_q)));

  // R9: flush empties at the next edge
  p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!out_valid && !full));

  // R5: break on a full queue without a read keeps it full
  p_brk_keeps_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_evt && full && !out_ready && !flush) |=> full);
endmodule

// File: rtl/rbq_brk.sv
module rbq_brk (
  input  logic clk,
  input  logic rst_n,
  input  logic brk_evt,
  input  logic brk_clr,
  output logic brk_flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_flag <= 1'b0;
    end else if (brk_evt) begin
      brk_flag <= 1'b1;
    end else if (brk_clr) begin
      brk_flag <= 1'b0;
    end
  end

  // R6: an event always leaves the flag set
  p_brk_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt |=> brk_flag);

  // R6: without event or clear the flag holds
  p_brk_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!brk_evt && !brk_clr) |=> $stable(brk_flag));
endmodule

// File: rtl/rx_byte_queue.sv
module rx_byte_queue #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              brk_evt,
  input  logic              brk_clr,
  input  logic              flush,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready,
  output logic              full,
  output logic              brk_flag
);
  logic              wr_en, wr_is_brk;
  logic [PTR_W-1:0]  wr_idx, rd_idx;
  logic [DATA_W-1:0] wr_data, head;

  rbq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_en     (rx_en),
    .in_valid  (in_valid),
    .brk_evt   (brk_evt),
    .flush     (flush),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .full      (full),
    .wr_en     (wr_en),
    .wr_is_brk (wr_is_brk),
    .wr_idx    (wr_idx),
    .rd_idx    (rd_idx)
  );

  assign wr_data = wr_is_brk ? '0 : in_data;

  rbq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_idx  (rd_idx),
    .rd_data (head)
  );

  rbq_brk u_brk (
    .clk      (clk),
    .rst_n    (rst_n),
    .brk_evt  (brk_evt),
    .brk_clr  (brk_clr),
    .brk_flag (brk_flag)
  );

  assign out_data = out_valid ? head : '0;

  // R7: empty queue reads as zero
  p_empty_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_data == '0));

  // R7: a read on an empty queue with nothing arriving keeps it empty
  p_empty_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && out_ready && !(in_valid && in_ready) && !brk_evt) |=> !out_valid);
endmodule

// File: tb/rx_byte_queue_tb.sv
module rx_byte_queue_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_en = 1'b0, in_valid = 1'b0, brk_evt = 1'b0, brk_clr = 1'b0;
  logic       flush = 1'b0, out_ready = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready, out_valid, full, brk_flag;
  logic [7:0] out_data;
  int         n_chk = 0;
  int         n_fail = 0;

  always #10 clk = ~clk;

  rx_byte_queue u_dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .brk_evt(brk_evt),
    .brk_clr(brk_clr), .flush(flush), .out_valid(out_valid),
    .out_data(out_data), .out_ready(out_ready), .full(full),
    .brk_flag(brk_flag)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic push_byte(input logic [7:0] b);
    in_valid = 1'b1;
    in_data  = b;
    tick();
    in_valid = 1'b0;
  endtask

  task automatic pop_expect(input logic [7:0] exp, input string tag);
    chk({tag, " valid"}, 32'(out_valid), 32'd1);
    chk({tag, " data"}, 32'(out_data), 32'(exp));
    out_ready = 1'b1;
    tick();
    out_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 out_valid", 32'(out_valid), 0);
    chk("R1 full", 32'(full), 0);
    chk("R1 brk_flag", 32'(brk_flag), 0);
    chk("R1 out_data", 32'(out_data), 0);
    chk("R1 in_ready", 32'(in_ready), 0);
    rx_en = 1'b1;
    #1 chk("R1 in_ready follows rx_en", 32'(in_ready), 1);
  endtask

  task automatic t_order();
    push_byte(8'hA1); push_byte(8'hA2); push_byte(8'hA3);
    chk("R4 not full at 3", 32'(full), 0);
    push_byte(8'hA4);
    chk("R4 full at 4", 32'(full), 1);
    chk("R2 in_ready low when full", 32'(in_ready), 0);
    in_valid = 1'b1; in_data = 8'hEE; tick(); in_valid = 1'b0;
    pop_expect(8'hA1, "R3 order 1");
    chk("R4 read clears full", 32'(full), 0);
    pop_expect(8'hA2, "R3 order 2");
    pop_expect(8'hA3, "R3 order 3");
    pop_expect(8'hA4, "R2 byte refused when full not stored");
    chk("R4 empty after drain", 32'(out_valid), 0);
  endtask

  task automatic t_disabled();
    rx_en = 1'b0;
    #1 chk("R2 in_ready low when disabled", 32'(in_ready), 0);
    push_byte(8'h99);
    chk("R2 disabled byte dropped", 32'(out_valid), 0);
    rx_en = 1'b1;
  endtask

  task automatic t_empty_pop();
    chk("R7 empty data zero", 32'(out_data), 0);
    out_ready = 1'b1; tick(); out_ready = 1'b0;
    chk("R7 empty read no change", 32'(out_valid), 0);
    push_byte(8'h55);
    pop_expect(8'h55, "R7 after empty read");
    chk("R7 empty again", 32'(out_valid), 0);
  endtask

  task automatic t_simul();
    push_byte(8'h11); push_byte(8'h22);
    chk("R8 head before", 32'(out_data), 32'h11);
    in_valid = 1'b1; in_data = 8'h33; out_ready = 1'b1;
    tick();
    in_valid = 1'b0; out_ready = 1'b0;
    pop_expect(8'h22, "R8 after simultaneous 1");
    pop_expect(8'h33, "R8 after simultaneous 2");
    chk("R8 count kept", 32'(out_valid), 0);
  endtask

  task automatic t_break_full();
    push_byte(8'hB1); push_byte(8'hB2); push_byte(8'hB3); push_byte(8'hB4);
    brk_evt = 1'b1;
    #1 chk("R2 in_ready low on break", 32'(in_ready), 0);
    tick(); brk_evt = 1'b0;
    chk("R5 still full", 32'(full), 1);
    chk("R6 flag set", 32'(brk_flag), 1);
    pop_expect(8'hB1, "R5 keep 1");
    pop_expect(8'hB2, "R5 keep 2");
    pop_expect(8'hB3, "R5 keep 3");
    pop_expect(8'h00, "R5 newest replaced");
    chk("R5 empty", 32'(out_valid), 0);
  endtask

  task automatic t_break_flag();
    brk_evt = 1'b1; tick(); brk_evt = 1'b0;
    chk("R5 break on empty appends", 32'(out_valid), 1);
    chk("R5 break byte zero", 32'(out_data), 0);
    brk_evt = 1'b1; brk_clr = 1'b1; tick(); brk_evt = 1'b0; brk_clr = 1'b0;
    chk("R6 set wins over clear", 32'(brk_flag), 1);
    tick();
    chk("R6 flag holds", 32'(brk_flag), 1);
    brk_clr = 1'b1; tick(); brk_clr = 1'b0;
    chk("R6 clear", 32'(brk_flag), 0);
    pop_expect(8'h00, "R5 zero 1");
    pop_expect(8'h00, "R5 zero 2");
    chk("R5 drained", 32'(out_valid), 0);
  endtask

  task automatic t_flush();
    push_byte(8'h41); push_byte(8'h42);
    in_valid = 1'b1; in_data = 8'h43; flush = 1'b1; out_ready = 1'b1;
    #1 chk("R9 in_ready low on flush", 32'(in_ready), 0);
    tick();
    in_valid = 1'b0; flush = 1'b0; out_ready = 1'b0;
    chk("R9 flushed empty", 32'(out_valid), 0);
    chk("R9 flushed not full", 32'(full), 0);
    push_byte(8'h77);
    pop_expect(8'h77, "R9 after flush");
    chk("R9 no stale byte", 32'(out_valid), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_order();
    t_disabled();
    t_empty_pop();
    t_simul();
    t_break_full();
    t_break_flag();
    t_flush();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule